// File: doc/BRIEF.md
# Serial ADC Sampling Controller

This block is an SPI master that takes one conversion from a family of serial successive-approximation converters. A static parameter picks the converter flavour. The flavours are 10-bit or 12-bit converters with 1, 2, 4 or 8 inputs, and one 13-bit signed differential flavour. The host raises a one-cycle request with a channel number and a differential flag. The controller then pulls chip select low and sends a command byte if the flavour needs one. It clocks in the reply in SPI mode 0, then releases chip select. It aligns the reply to a right-justified result and presents it with a one-cycle valid pulse.

The SPI clock is the system clock divided by an even parameter. Data leaves the master MSB first on the falling edge, and the reply is sampled on the rising edge. After each conversion, chip select stays high for at least one SPI clock period before the next transfer can start. A request whose channel number is beyond the flavour's input count raises an error pulse and starts nothing.

Top module: `adc_spi_reader`

## Requirements
- R1: While reset is asserted and straight after it, cs_no is 1 and sclk_o, mosi_o, busy_o, valid_o and err_o are 0.
- R2: During a transfer each SPI clock period lasts CLK_DIV system cycles. The clock is low for the first half and high for the second half. sclk_o is low whenever cs_no is high.
- R3: An accepted request pulls cs_no low on the next clock edge. cs_no stays low for 16 SPI periods on single-input flavours and 24 on all others. miso_i is sampled at each rising sclk_o edge, and the last 16 sampled bits form the reply, first byte in bits 15:8.
- R4: mosi_o carries the command byte MSB first and changes only when sclk_o falls or cs_no falls. It is 0 for every bit after the command, for every bit on single-input flavours, and whenever cs_no is high.
- R5: On 2-input flavours the command byte has bit 4 = 1 (start) and bit 3 = single-ended flag. Bit 2 is channel bit 0, and all other bits are 0.
- R6: On 4- and 8-input flavours the command byte has bit 6 = 1 (start) and bit 5 = single-ended flag. Bits 4:2 hold the channel number, and the other bits are 0.
- R7: The single-ended flag is the inverse of diff_i. A differential request on channel N measures N against N XOR 1, with N positive. The channel field therefore carries N unchanged, so both orderings of a pair can be requested.
- R8: Multi-input results, with reply bytes b0 (first) and b1: the 10-bit result is (b0<<2)|(b1>>6) and the 12-bit result is (b0<<4)|(b1>>4), zero-extended.
- R9: Single-input results: the 10-bit result is (b0<<5)|(b1>>3) and the 12-bit result is (b0<<7)|(b1>>1), zero-extended.
- R10: The 13-bit flavour returns {b0[4:0], b1} as two's complement, sign-extended from bit 12 to OUT_W bits.
- R11: valid_o pulses for exactly one cycle, in the cycle in which cs_no has just risen. data_o holds the result until the next valid pulse.
- R12: busy_o is high from the cycle after acceptance until CLK_DIV cycles after cs_no rises. A request seen while busy_o is high is ignored.
- R13: A request with chan_i not below the flavour's input count raises err_o for one cycle. It leaves cs_no high and busy_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Conversion request, sampled when idle |
| chan_i | input | 3 | Requested channel number |
| diff_i | input | 1 | 1 = differential pair, 0 = single-ended |
| busy_o | output | 1 | Transfer or chip-select gap in progress |
| valid_o | output | 1 | One-cycle result strobe |
| data_o | output | OUT_W | Aligned conversion result |
| err_o | output | 1 | One-cycle pulse on a rejected channel |
| sclk_o | output | 1 | SPI clock, idle low |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Command data to converter |
| miso_i | input | 1 | Reply data from converter |

## Verification
A wrong phase or bit counter shows up at the pins within one SPI period. sclk_o rises or falls on the wrong system cycle, or cs_no rises early or late. A per-clock model of the pin timing flags it at that same cycle. A wrong command byte, wrong alignment or wrong sign handling does not show until the valid pulse at the end of that conversion. There the data and the captured MOSI bits are compared against values computed from the reply word. A stuck state machine shows as busy_o or cs_no differing from the model in the first cycle where the model leaves its state.

// File: rtl/adc_spi_pkg.sv
package adc_spi_pkg;

  typedef enum logic [3:0] {
    V10_CH1, V10_CH2, V10_CH4, V10_CH8,
    V12_CH1, V12_CH2, V12_CH4, V12_CH8,
    V13_DIFF
  } variant_e;

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_GAP} state_e;

  function automatic int unsigned num_inputs(variant_e v);
    case (v)
      V10_CH2, V12_CH2: return 2;
      V10_CH4, V12_CH4: return 4;
      V10_CH8, V12_CH8: return 8;
      default:          return 1;
    endcase
  endfunction

  function automatic bit is_10bit(variant_e v);
    return (v == V10_CH1) || (v == V10_CH2) || (v == V10_CH4) || (v == V10_CH8);
  endfunction

endpackage

// File: rtl/adc_spi_clkgen.sv
module adc_spi_clkgen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int HALF = CLK_DIV / 2;
  localparam int PH_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

  logic [PH_W-1:0] ph_q;

  assign rise_o = run_i && (ph_q == PH_W'(HALF - 1));
  assign fall_o = run_i && (ph_q == PH_W'(CLK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      sclk_o <= 1'b0;
    end else if (!run_i) begin
      ph_q   <= '0;
      sclk_o <= 1'b0;
    end else begin
      ph_q <= fall_o ? '0 : ph_q + 1'b1;
      if (rise_o)      sclk_o <= 1'b1;
      else if (fall_o) sclk_o <= 1'b0;
    end
  end

  // R2
  low_before_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> !sclk_o);

  // R2
  high_before_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> sclk_o);

endmodule

// File: rtl/adc_spi_cmd.sv
module adc_spi_cmd
  import adc_spi_pkg::*;
#(
  parameter variant_e VARIANT = V12_CH8
) (
  input  logic [2:0] chan_i,
  input  logic       diff_i,
  output logic [7:0] cmd_o
);
  localparam int unsigned NIN = num_inputs(VARIANT);

  logic unused_in;
  assign unused_in = ^{chan_i, diff_i};

  generate
    if (NIN == 1) begin : g_none
      assign cmd_o = 8'h00;
    end else if (NIN == 2) begin : g_two
      assign cmd_o = {3'b000, 1'b1, ~diff_i, chan_i[0], 2'b00};
    end else begin : g_wide
      assign cmd_o = {1'b0, 1'b1, ~diff_i, chan_i, 2'b00};
    end
  endgenerate

endmodule

// File: rtl/adc_spi_align.sv
module adc_spi_align
  import adc_spi_pkg::*;
#(
  parameter variant_e VARIANT = V12_CH8,
  parameter int       OUT_W   = 16
) (
  input  logic [15:0]      rx_i,
  output logic [OUT_W-1:0] data_o
);
  localparam int unsigned NIN = num_inputs(VARIANT);
  localparam bit          R10 = is_10bit(VARIANT);

  logic [7:0]  b0, b1;
  logic [15:0] raw;
  logic        unused_rx;

  assign b0 = rx_i[15:8];
  assign b1 = rx_i[7:0];
  assign unused_rx = ^rx_i;

  generate
    if (VARIANT == V13_DIFF) begin : g_signed
      assign raw    = {3'b000, b0[4:0], b1};
      assign data_o = {{(OUT_W-13){raw[12]}}, raw[12:0]};
    end else begin : g_unsigned
      if (NIN == 1 && R10) begin : g_s10
        assign raw = {3'b000, b0, b1[7:3]};
      end else if (NIN == 1) begin : g_s12
        assign raw = {1'b0, b0, b1[7:1]};
      end else if (R10) begin : g_m10
        assign raw = {6'b0, b0, b1[7:6]};
      end else begin : g_m12
        assign raw = {4'b0, b0, b1[7:4]};
      end
      assign data_o = {{(OUT_W-16){1'b0}}, raw};
    end
  endgenerate

endmodule

// File: rtl/adc_spi_reader.sv
module adc_spi_reader
  import adc_spi_pkg::*;
#(
  parameter variant_e VARIANT = V12_CH8,
  parameter int       CLK_DIV = 4,
  parameter int       OUT_W   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [2:0]       chan_i,
  input  logic             diff_i,
  output logic             busy_o,
  output logic             valid_o,
  output logic [OUT_W-1:0] data_o,
  output logic             err_o,
  output logic             sclk_o,
  output logic             cs_no,
  output logic             mosi_o,
  input  logic             miso_i
);
  localparam int unsigned NIN   = num_inputs(VARIANT);
  localparam int          NBITS = (NIN > 1) ? 24 : 16;
  localparam int          CNT_W = $clog2(NBITS);
  localparam int          PH_W  = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

  state_e           state_q;
  logic [CNT_W-1:0] bit_cnt_q;
  logic [PH_W-1:0]  gap_q;
  logic [7:0]       tx_q;
  logic [15:0]      rx_q;
  logic [OUT_W-1:0] data_q;
  logic             cs_n_q, valid_q, err_q;
  logic             rise, fall, run, chan_bad;
  logic [7:0]       cmd;
  logic [OUT_W-1:0] aligned;

  assign run      = (state_q == ST_XFER);
  assign chan_bad = (32'(chan_i) >= NIN);

  adc_spi_clkgen #(.CLK_DIV(CLK_DIV)) u_clk (
    .clk_i, .rst_ni, .run_i(run), .sclk_o, .rise_o(rise), .fall_o(fall)
  );

  adc_spi_cmd #(.VARIANT(VARIANT)) u_cmd (
    .chan_i, .diff_i, .cmd_o(cmd)
  );

  adc_spi_align #(.VARIANT(VARIANT), .OUT_W(OUT_W)) u_align (
    .rx_i(rx_q), .data_o(aligned)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cs_n_q    <= 1'b1;
      bit_cnt_q <= '0;
      gap_q     <= '0;
      tx_q      <= '0;
      rx_q      <= '0;
      data_q    <= '0;
      valid_q   <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          if (chan_bad) begin
            err_q <= 1'b1;
          end else begin
            state_q   <= ST_XFER;
            cs_n_q    <= 1'b0;
            bit_cnt_q <= '0;
            tx_q      <= cmd;
            rx_q      <= '0;   // no stale bits into the result
          end
        end
        ST_XFER: begin
          if (rise) rx_q <= {rx_q[14:0], miso_i};
          if (fall) begin
            if (bit_cnt_q == CNT_W'(NBITS - 1)) begin
              state_q <= ST_GAP;
              cs_n_q  <= 1'b1;
              gap_q   <= '0;
              valid_q <= 1'b1;
              data_q  <= aligned;
            end else begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
              tx_q      <= {tx_q[6:0], 1'b0};
            end
          end
        end
        ST_GAP: begin
          if (gap_q == PH_W'(CLK_DIV - 1)) state_q <= ST_IDLE;
          else                             gap_q   <= gap_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign err_o   = err_q;
  assign cs_no   = cs_n_q;
  assign mosi_o  = tx_q[7];

  // R2
  sclk_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_q |-> !sclk_o);

  // R4
  mosi_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_q |-> !mosi_o);

  // R11
  valid_at_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $rose(cs_n_q));

  // R11
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R12
  cs_fall_from_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_q) |-> $past(!busy_o && req_i));

  // R12
  gap_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_q) |=> (busy_o && cs_n_q));

  // R13
  err_no_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (cs_n_q && !busy_o && !valid_o));

  // R10
  sign_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && VARIANT == V13_DIFF) |-> (data_o[OUT_W-1] == data_o[12]));

endmodule

// File: tb/adc_spi_reader_tb.sv
module adc_spi_reader_harness
  import adc_spi_pkg::*;
#(
  parameter variant_e VAR = V12_CH8,
  parameter int       D   = 4
) (
  input  logic clk,
  input  logic rst_n,
  output int   errs,
  output int   checks,
  output logic done
);
  function automatic int inputs_of(variant_e v);
    if (v == V10_CH2 || v == V12_CH2) return 2;
    if (v == V10_CH4 || v == V12_CH4) return 4;
    if (v == V10_CH8 || v == V12_CH8) return 8;
    return 1;
  endfunction

  localparam int NIN  = inputs_of(VAR);
  localparam int NB   = (NIN > 1) ? 24 : 16;
  localparam int HALF = D / 2;
  localparam bit TEN  = (VAR == V10_CH1 || VAR == V10_CH2 || VAR == V10_CH4 || VAR == V10_CH8);

  logic        req, diff, miso;
  logic [2:0]  chan;
  logic        busy_o, valid_o, err_o, sclk_o, cs_no, mosi_o;
  logic [15:0] data_o;

  adc_spi_reader #(.VARIANT(VAR), .CLK_DIV(D), .OUT_W(16)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .chan_i(chan), .diff_i(diff),
    .busy_o, .valid_o, .data_o, .err_o, .sclk_o, .cs_no, .mosi_o, .miso_i(miso)
  );

  // converter model: all-ones during command bits, then reply word
  logic [15:0] rep;
  logic [23:0] sw;
  int          bitpos = 99;
  assign sw   = (NIN > 1) ? {8'hFF, rep} : {8'h00, rep};
  assign miso = (bitpos >= 0 && bitpos < NB) ? sw[NB-1-bitpos] : 1'b0;
  always @(negedge cs_no) bitpos = 0;
  always @(negedge sclk_o) if (!cs_no) bitpos++;

  logic [23:0] mw;
  always @(negedge cs_no) mw = '0;
  always @(posedge sclk_o) mw = {mw[22:0], mosi_o};

  function automatic logic [15:0] exp_data(logic [15:0] w);
    int b0, b1, v;
    b0 = int'(w[15:8]);
    b1 = int'(w[7:0]);
    if (VAR == V13_DIFF) begin
      v = ((b0 & 31) << 8) | b1;
      if (v >= 4096) v -= 8192;
    end else if (NIN == 1) v = TEN ? ((b0 << 5) | (b1 >> 3)) : ((b0 << 7) | (b1 >> 1));
    else                   v = TEN ? ((b0 << 2) | (b1 >> 6)) : ((b0 << 4) | (b1 >> 4));
    return 16'(v);
  endfunction

  // behavioural reference: mode 0 idle, 1 transfer, 2 gap
  int          m = 0, t = 0, g = 0, pch = 0;
  bit          pdf, ve, ee;
  logic [15:0] prep, dexp;

  always @(posedge clk) begin
    if (!rst_n) begin
      m = 0; t = 0; g = 0; ve = 0; ee = 0;
    end else begin
      ve = 0; ee = 0;
      case (m)
        0: if (req) begin
          if (int'(chan) >= NIN) ee = 1;
          else begin m = 1; t = 0; pch = int'(chan); pdf = diff; prep = rep; end
        end
        1: begin
          t++;
          if (t == NB * D) begin m = 2; g = 0; ve = 1; dexp = exp_data(prep); end
        end
        default: begin g++; if (g == D) m = 0; end
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s var=%0d act=%0h exp=%0h t=%0t", tag, VAR, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    int cmd_e;
    if (!rst_n) begin
      chk({cs_no, sclk_o, mosi_o, busy_o, valid_o, err_o} == 6'b100000, "R1 reset",
          int'({cs_no, sclk_o, mosi_o, busy_o, valid_o, err_o}), 32);
    end else begin
      chk(sclk_o == ((m == 1) && ((t % D) >= HALF)), "R2 sclk", int'(sclk_o),
          int'((m == 1) && ((t % D) >= HALF)));
      chk(cs_no == (m != 1), "R3 cs", int'(cs_no), int'(m != 1));
      chk(busy_o == (m != 0), "R12 busy", int'(busy_o), int'(m != 0));
      chk(valid_o == ve, "R11 valid", int'(valid_o), int'(ve));
      chk(err_o == ee, "R13 err", int'(err_o), int'(ee));
      if (m != 1) chk(mosi_o == 1'b0, "R4 mosi idle", int'(mosi_o), 0);
      if (ve) begin
        chk(data_o == dexp, (VAR == V13_DIFF) ? "R10 data" : (NIN == 1) ? "R9 data" : "R8 data",
            int'(data_o), int'(dexp));
        chk(mw[15:0] == 16'h0, "R4 mosi tail", int'(mw[15:0]), 0);
        if (NIN > 1) begin
          if (NIN == 2) cmd_e = 16 | ((pdf ? 0 : 1) << 3) | ((pch & 1) << 2);
          else          cmd_e = 64 | ((pdf ? 0 : 1) << 5) | (pch << 2);
          chk(int'(mw[23:16]) == cmd_e, pdf ? "R7 cmd" : ((NIN == 2) ? "R5 cmd" : "R6 cmd"),
              int'(mw[23:16]), cmd_e);
        end
      end
    end
  end

  task automatic issue(input int c, input bit d, input logic [15:0] w);
    while (m != 0) @(negedge clk);
    rep = w; chan = 3'(c); diff = d; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (2) @(negedge clk);
    while (m != 0) @(negedge clk);
  endtask

  // R12: requests during transfer and gap are dropped
  task automatic issue_busy(input int c, input bit d, input logic [15:0] w);
    while (m != 0) @(negedge clk);
    rep = w; chan = 3'(c); diff = d; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (3 * D) @(negedge clk);
    chan = 3'((c + 1) % NIN); diff = !d; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    while (m != 2) @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    while (m != 0) @(negedge clk);
  endtask

  initial begin
    errs = 0; checks = 0; done = 1'b0;
    req = 1'b0; chan = '0; diff = 1'b0; rep = '0;
    @(posedge rst_n);
    repeat (3) @(negedge clk);
    for (int c = 0; c < NIN; c++) issue(c, 1'b0, 16'hA5C3 ^ 16'(c * 16'h1111));
    issue(0, 1'b1, 16'hFFFF);                      // R7
    issue((NIN > 1) ? 1 : 0, 1'b1, 16'h0000);      // R7 reversed pair
    issue(0, 1'b0, 16'h1000);                      // R10 most negative
    issue(0, 1'b0, 16'h0FFF);                      // R10 most positive
    issue(0, 1'b0, 16'hE0F1);
    if (NIN < 8) begin
      issue(NIN, 1'b0, 16'h1234);                  // R13
      issue(7, 1'b1, 16'h1234);                    // R13
    end
    issue_busy(0, 1'b0, 16'h3C5A);
    issue(NIN - 1, 1'b1, 16'h5A3C);
    repeat (5) @(negedge clk);
    done = 1'b1;
  end
endmodule

module adc_spi_reader_tb;
  import adc_spi_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  always #4 clk = ~clk;

  int   e0, e1, e2, e3, e4, c0, c1, c2, c3, c4;
  logic d0, d1, d2, d3, d4;

  adc_spi_reader_harness #(.VAR(V10_CH2),  .D(4)) h0 (.clk, .rst_n, .errs(e0), .checks(c0), .done(d0));
  adc_spi_reader_harness #(.VAR(V12_CH8),  .D(4)) h1 (.clk, .rst_n, .errs(e1), .checks(c1), .done(d1));
  adc_spi_reader_harness #(.VAR(V10_CH1),  .D(2)) h2 (.clk, .rst_n, .errs(e2), .checks(c2), .done(d2));
  adc_spi_reader_harness #(.VAR(V12_CH1),  .D(6)) h3 (.clk, .rst_n, .errs(e3), .checks(c3), .done(d3));
  adc_spi_reader_harness #(.VAR(V13_DIFF), .D(4)) h4 (.clk, .rst_n, .errs(e4), .checks(c4), .done(d4));

  initial begin
    int wd_err;
    int cyc;
    wd_err = 0;
    #1 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!(d0 && d1 && d2 && d3 && d4) && cyc < 150000) begin
      @(negedge clk);
      cyc++;
    end
    if (!(d0 && d1 && d2 && d3 && d4)) begin
      wd_err = 1;
      $display("FAIL watchdog act=%0d exp=done", cyc);
    end
    $display("Result: errors=%0d of %0d checks",
             e0 + e1 + e2 + e3 + e4 + wd_err, c0 + c1 + c2 + c3 + c4 + 1);
    $finish;
  end
endmodule